// File: doc/BRIEF.md
# Scaled OFDM Constellation Mapper

The mapper turns one group of coded bits per transfer into a complex fixed-point point (I, Q) for an OFDM transmitter. A two-bit scheme code selects BPSK, QPSK, 16-QAM or 64-QAM. Every scheme uses the same scale factor, sqrt(42)/7 × (1 − 2^-15). With that factor the outermost 64-QAM level lands exactly on the largest positive value of a signed 16-bit number with 15 fractional bits. All other points fall inside that range, so the IFFT that follows needs no per-scheme gain.

The level tables hold rounded signed 16-bit constants. The point comes out of a single register stage. Both sides of the block are valid/ready streams. A transfer happens on a rising clock edge where valid and ready are both high. The input is accepted whenever the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While the output is held back, the point and its valid flag stay unchanged. `out_valid` never drops until the consumer takes the point.

Top module: `ofdm_cmap`

## Requirements
- R1: During reset and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Scheme code 0 is BPSK (1 bit per point), 1 is QPSK (2 bits), 2 is 16-QAM (4 bits) and 3 is 64-QAM (6 bits). The I index is taken from the low half of the used bits, with `in_bits[0]` as the index LSB. The Q index is taken from the next half.
- R3: BPSK: `in_bits[0]` = 0 gives I = −30336 and `in_bits[0]` = 1 gives I = +30336. Q is always 0.
- R4: QPSK: `in_bits[0]` selects I and `in_bits[1]` selects Q. Index 0 gives −21451 and index 1 gives +21451.
- R5: 16-QAM: `in_bits[1:0]` indexes I and `in_bits[3:2]` indexes Q. Indices 0, 1, 2, 3 give −28780, −9593, +28780, +9593.
- R6: 64-QAM: `in_bits[2:0]` indexes I and `in_bits[5:3]` indexes Q. Indices 0 to 7 give −32767, −23405, −4681, −14043, +32767, +23405, +4681, +14043.
- R7: Bits of `in_bits` above those the scheme uses have no effect on the point.
- R8: A point accepted on an edge appears at the output, with `out_valid` high, right after that edge.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_i`, `out_q` and `out_valid` hold their values.
- R10: No output value is ever −32768. The range is symmetric.
- R11: With `out_ready` held high, one point is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input bit group is valid |
| in_ready | output | 1 | Mapper can take a bit group |
| in_bits | input | 6 | Coded bit group, LSB first |
| in_mod | input | 2 | Scheme code (0 BPSK, 1 QPSK, 2 16-QAM, 3 64-QAM) |
| out_valid | output | 1 | Output point is valid |
| out_ready | input | 1 | Consumer takes the point |
| out_i | output | 16 | In-phase value, signed Q1.15 |
| out_q | output | 16 | Quadrature value, signed Q1.15 |

## Verification
The bench covers every level index of each scheme, with the I and Q indices chosen so that a swapped half or a reversed bit order gives a visibly wrong point. The non-monotone index orders of 16-QAM and 64-QAM are stressed, since a design that used natural ordering would swap the −1/−3 and +1/+3 levels. Groups with junk in the unused upper bits catch a decoder that reads past the scheme's width. A stall test holds `out_ready` low while a second group waits. This exposes a stage that overwrites or drops the held point, or that lowers valid before the point is taken.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  localparam int SAMP_W  = 16;
  localparam int GROUP_W = 6;
  localparam int IDX_W   = GROUP_W / 2;

  typedef enum logic [1:0] {
    MOD_BPSK  = 2'd0,
    MOD_QPSK  = 2'd1,
    MOD_QAM16 = 2'd2,
    MOD_QAM64 = 2'd3
  } mod_t;

  typedef logic signed [SAMP_W-1:0] samp_t;

  // Full scale in Q1.15 is 32767. The common scale maps a unit amplitude to
  // 32767*sqrt(42)/7 = 30336.35.
  // Each magnitude below is that value times the scheme's normalised level,
  // rounded to the nearest integer.
  localparam samp_t AMP_BPSK    = 16'sd30336; // 1
  localparam samp_t AMP_QPSK    = 16'sd21451; // 1/sqrt(2)
  localparam samp_t AMP_Q16_LO  = 16'sd9593;  // 1/sqrt(10)
  localparam samp_t AMP_Q16_HI  = 16'sd28780; // 3/sqrt(10)
  localparam samp_t AMP_Q64_1   = 16'sd4681;  // 1/sqrt(42)
  localparam samp_t AMP_Q64_3   = 16'sd14043; // 3/sqrt(42)
  localparam samp_t AMP_Q64_5   = 16'sd23405; // 5/sqrt(42)
  localparam samp_t AMP_Q64_7   = 16'sd32767; // 7/sqrt(42)

  localparam samp_t SAMP_MIN = {1'b1, {(SAMP_W-1){1'b0}}};

  // The index MSB selects the sign; the lower bits pick a magnitude in a
  // Gray-like order (outer level first on each side).
  function automatic samp_t axis_level(mod_t m, logic [IDX_W-1:0] idx);
    samp_t mag;
    logic  neg;
    mag = '0;
    neg = 1'b0;
    unique case (m)
      MOD_BPSK: begin
        neg = ~idx[0];
        mag = AMP_BPSK;
      end
      MOD_QPSK: begin
        neg = ~idx[0];
        mag = AMP_QPSK;
      end
      MOD_QAM16: begin
        neg = ~idx[1];
        mag = idx[0] ? AMP_Q16_LO : AMP_Q16_HI;
      end
      default: begin
        neg = ~idx[2];
        unique case (idx[1:0])
          2'd0:    mag = AMP_Q64_7;
          2'd1:    mag = AMP_Q64_5;
          2'd2:    mag = AMP_Q64_1;
          default: mag = AMP_Q64_3;
        endcase
      end
    endcase
    return neg ? -mag : mag;
  endfunction

endpackage

// File: rtl/cmap_index_split.sv
module cmap_index_split
  import cmap_pkg::*;
(
  input  logic [GROUP_W-1:0] bits_i,
  input  mod_t               mod_i,
  output logic [IDX_W-1:0]   i_idx_o,
  output logic [IDX_W-1:0]   q_idx_o
);

  always_comb begin
    i_idx_o = '0;
    q_idx_o = '0;
    unique case (mod_i)
      MOD_BPSK: begin
        i_idx_o[0] = bits_i[0];
      end
      MOD_QPSK: begin
        i_idx_o[0] = bits_i[0];
        q_idx_o[0] = bits_i[1];
      end
      MOD_QAM16: begin
        i_idx_o[1:0] = bits_i[1:0];
        q_idx_o[1:0] = bits_i[3:2];
      end
      default: begin
        i_idx_o = bits_i[IDX_W-1:0];
        q_idx_o = bits_i[GROUP_W-1:IDX_W];
      end
    endcase
  end

endmodule

// File: rtl/cmap_axis_lut.sv
module cmap_axis_lut
  import cmap_pkg::*;
#(
  parameter bit IS_Q = 1'b0
) (
  input  mod_t             mod_i,
  input  logic [IDX_W-1:0] idx_i,
  output samp_t            level_o
);

  generate
    if (IS_Q) begin : g_q_axis
      always_comb begin
        if (mod_i == MOD_BPSK) level_o = '0;
        else                   level_o = axis_level(mod_i, idx_i);
      end
    end else begin : g_i_axis
      always_comb level_o = axis_level(mod_i, idx_i);
    end
  endgenerate

  // R10: the table never yields the asymmetric minimum
  always_comb begin
    a_r10_lut_range: assert (level_o != SAMP_MIN);
  end

endmodule

// File: rtl/cmap_out_reg.sv
module cmap_out_reg
  import cmap_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  samp_t in_i,
  input  samp_t in_q,
  output logic  out_valid,
  input  logic  out_ready,
  output samp_t out_i,
  output samp_t out_q
);

  logic  v_q;
  samp_t i_q;
  samp_t q_q;

  assign in_ready  = !v_q || out_ready;
  assign out_valid = v_q;
  assign out_i     = i_q;
  assign out_q     = q_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      i_q <= '0;
      q_q <= '0;
    end else if (in_ready) begin
      v_q <= in_valid;
      if (in_valid) begin
        i_q <= in_i;
        q_q <= in_q;
      end
    end
  end

  a_r9_hold_point: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_i) && $stable(out_q)));

  a_r9_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r10_out_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_i != SAMP_MIN && out_q != SAMP_MIN));

endmodule

// File: rtl/ofdm_cmap.sv
module ofdm_cmap
  import cmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [GROUP_W-1:0] in_bits,
  input  logic [1:0]         in_mod,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SAMP_W-1:0]  out_i,
  output logic [SAMP_W-1:0]  out_q
);

  mod_t             mod_s;
  logic [IDX_W-1:0] i_idx;
  logic [IDX_W-1:0] q_idx;
  samp_t            i_lvl;
  samp_t            q_lvl;
  samp_t            oi;
  samp_t            oq;

  assign mod_s = mod_t'(in_mod);

  cmap_index_split u_split (
    .bits_i  (in_bits),
    .mod_i   (mod_s),
    .i_idx_o (i_idx),
    .q_idx_o (q_idx)
  );

  cmap_axis_lut #(.IS_Q(1'b0)) u_lut_i (
    .mod_i   (mod_s),
    .idx_i   (i_idx),
    .level_o (i_lvl)
  );

  cmap_axis_lut #(.IS_Q(1'b1)) u_lut_q (
    .mod_i   (mod_s),
    .idx_i   (q_idx),
    .level_o (q_lvl)
  );

  cmap_out_reg u_oreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_i      (i_lvl),
    .in_q      (q_lvl),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (oi),
    .out_q     (oq)
  );

  assign out_i = oi;
  assign out_q = oq;

  a_r3_bpsk_q_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_mod == 2'd0) |=> (out_q == '0));

  a_r11_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

// File: tb/tb_ofdm_cmap.sv
module tb_ofdm_cmap;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [1:0]         m;
    logic [5:0]         b;
    logic signed [15:0] ei;
    logic signed [15:0] eq;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 6'b000000, -16'sd30336,  16'sd0},
    '{2'd0, 6'b000001,  16'sd30336,  16'sd0},
    '{2'd0, 6'b111110, -16'sd30336,  16'sd0},
    '{2'd1, 6'b000000, -16'sd21451, -16'sd21451},
    '{2'd1, 6'b000001,  16'sd21451, -16'sd21451},
    '{2'd1, 6'b000010, -16'sd21451,  16'sd21451},
    '{2'd1, 6'b111101,  16'sd21451, -16'sd21451},
    '{2'd2, 6'b000000, -16'sd28780, -16'sd28780},
    '{2'd2, 6'b000110,  16'sd28780, -16'sd9593},
    '{2'd2, 6'b001101, -16'sd9593,   16'sd9593},
    '{2'd2, 6'b111011,  16'sd9593,   16'sd28780},
    '{2'd3, 6'b000000, -16'sd32767, -16'sd32767},
    '{2'd3, 6'b100011, -16'sd14043,  16'sd32767},
    '{2'd3, 6'b010101,  16'sd23405, -16'sd4681},
    '{2'd3, 6'b111110,  16'sd4681,   16'sd14043},
    '{2'd3, 6'b001111,  16'sd14043, -16'sd23405},
    '{2'd3, 6'b110100,  16'sd32767,  16'sd4681}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_bits = '0;
  logic [1:0]  in_mod = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_i;
  logic [15:0] out_q;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ofdm_cmap dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bits   (in_bits),
    .in_mod    (in_mod),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_i     (out_i),
    .out_q     (out_q)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what,
               $signed(got), $signed(exp));
    end
  endtask

  function automatic string mod_tag(input logic [1:0] m);
    case (m)
      2'd0:    return "R3";
      2'd1:    return "R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic drive(input logic v, input logic [1:0] m, input logic [5:0] b);
    in_valid = v;
    in_mod   = m;
    in_bits  = b;
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1", "in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);

    // Table walk, back to back (R2, R7, R8, R11)
    drive(1'b1, VEC[0].m, VEC[0].b);
    for (int k = 0; k < NV; k++) begin
      check("R11", "in_ready streaming", {31'd0, in_ready}, 32'd1);
      @(negedge clk);
      check("R8", "out_valid", {31'd0, out_valid}, 32'd1);
      check(mod_tag(VEC[k].m), "I level (R2 split)",
            {{16{out_i[15]}}, out_i}, {{16{VEC[k].ei[15]}}, VEC[k].ei});
      check(mod_tag(VEC[k].m), "Q level (R2 split, R7 upper bits)",
            {{16{out_q[15]}}, out_q}, {{16{VEC[k].eq[15]}}, VEC[k].eq});
      if (k + 1 < NV) drive(1'b1, VEC[k+1].m, VEC[k+1].b);
      else            drive(1'b0, 2'd0, 6'd0);
    end
    @(negedge clk);
    check("R8", "out_valid drops when idle", {31'd0, out_valid}, 32'd0);

    // R9: back-pressure holds the point and blocks input
    out_ready = 1'b0;
    drive(1'b1, 2'd3, 6'b000000);
    @(negedge clk);
    drive(1'b1, 2'd0, 6'b000001);
    repeat (2) @(negedge clk);
    check("R9", "out_valid held", {31'd0, out_valid}, 32'd1);
    check("R9", "in_ready low in stall", {31'd0, in_ready}, 32'd0);
    check("R9", "I held", {{16{out_i[15]}}, out_i}, -32'sd32767);
    check("R9", "Q held", {{16{out_q[15]}}, out_q}, -32'sd32767);
    out_ready = 1'b1;
    @(negedge clk);
    drive(1'b0, 2'd0, 6'd0);
    check("R9", "waiting group taken after release", {{16{out_i[15]}}, out_i}, 32'sd30336);
    check("R3", "BPSK Q zero after stall", {{16{out_q[15]}}, out_q}, 32'd0);
    @(negedge clk);
    check("R9", "drained", {31'd0, out_valid}, 32'd0);

    // R10: symmetric range on the most negative 64-QAM point
    drive(1'b1, 2'd3, 6'b000000);
    @(negedge clk);
    drive(1'b0, 2'd0, 6'd0);
    check("R10", "no -32768 on I", {31'd0, (out_i == 16'h8000)}, 32'd0);
    check("R10", "no -32768 on Q", {31'd0, (out_q == 16'h8000)}, 32'd0);

    // R1: reset mid-stream clears valid
    drive(1'b1, 2'd1, 6'b000011);
    out_ready = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 6'd0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "out_valid cleared by reset", {31'd0, out_valid}, 32'd0);
    check("R1", "in_ready after re-reset", {31'd0, in_ready}, 32'd1);
    out_ready = 1'b1;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule